// File: doc/BRIEF.md
# Transmit retry status tracker

This block sits between software and a single-frame transmit engine for a shared one-wire control bus. Software writes the frame bytes into a small buffer, writes the frame length (header byte plus data bytes), programs a retry limit and sets an enable bit. The block then asks the attempt engine for one attempt at a time. Each attempt reports one of four outcomes: acknowledged, not acknowledged, line held low, or arbitration lost.

Every failed attempt that is not an arbitration loss adds one to one of two 4-bit failure counters. The block retries until the limit is used up. Each frame ends with exactly one of three sticky interrupt bits: ready, arbitration lost or retry timeout. The enable bit reads back as 1 for as long as the frame is in progress, so software can tell a live completion from a stale one. Bit timing on the wire is left out of scope. It is replaced by a request/done handshake with the attempt engine.

Register map (8-bit data): frame buffer at 0x00–0x0F, length at 0x10, retry limit at 0x11 bits [6:4], enable at 0x12 bit 0, interrupt status at 0x13 (bit 0 ready, bit 1 arbitration lost, bit 2 retry timeout), failure counters at 0x14 (bits [3:0] not-acknowledged count, bits [7:4] low-drive count). Outcome codes on `att_result`: 0 acknowledged, 1 not acknowledged, 2 line held low, 3 arbitration lost.

Top module: `txr_frame_ctrl`

## Requirements
- R1: After reset, all registers read 0, `att_req` is 0 and all three interrupt outputs are 0.
- R2: A write of 1 to bit 0 of the enable register (0x12) while idle, with a nonzero length, starts a frame. From the next cycle the enable bit reads 1, `att_req` is 1 and the counter register (0x14) reads 0.
- R3: Frame byte i is written at address i (0x00–0x0F). The attempt engine reads it on `att_byte` by putting i on `att_idx`. `att_len` shows the length register. A length write above 16 is stored as 16.
- R4: An outcome of 0 (acknowledged) on `att_done` sets interrupt bit 0 (ready). From the next cycle the enable bit reads 0 and `att_req` is 0.
- R5: An outcome of 3 (arbitration lost) ends the frame at once. It sets interrupt bit 1 only, starts no further attempt and leaves the counters unchanged.
- R6: An outcome of 1 adds one to counter bits [3:0]. An outcome of 2 adds one to counter bits [7:4]. Each failed attempt changes exactly one counter, and the counters keep their values after the frame ends.
- R7: With retry limit L at 0x11 bits [6:4], at most L+1 attempts are made. After a failed attempt that leaves attempts to spare, `att_req` drops for one cycle and then rises again. The failure that exhausts the attempts sets interrupt bit 2 (retry timeout) and clears the enable bit.
- R8: A start with length 0 makes no attempt. It sets retry timeout, leaves the enable bit at 0 and leaves both counters at 0.
- R9: While a frame is in progress, writes to the enable register, the frame buffer, the length register and the retry register have no effect.
- R10: Writing 1 to an interrupt status bit clears it, and writing 0 leaves it. If an interrupt is set in the same cycle as its clear, the set wins.
- R11: Each frame raises exactly one of the three interrupts.
- R12: Starting a new frame clears both failure counters left over from the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for writes and reads |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Read data for reg_addr (combinational) |
| att_req | output | 1 | Request for one transmit attempt, held until att_done |
| att_len | output | 5 | Frame length seen by the attempt engine |
| att_idx | input | 4 | Frame byte index chosen by the attempt engine |
| att_byte | output | 8 | Frame byte at att_idx |
| att_done | input | 1 | One-cycle pulse: attempt finished |
| att_result | input | 2 | Outcome code sampled with att_done |
| irq_ready | output | 1 | Sticky: frame acknowledged |
| irq_arb_lost | output | 1 | Sticky: arbitration lost |
| irq_retry_timeout | output | 1 | Sticky: attempts exhausted or zero length |

## Verification
The hardest condition to reach is the last permitted attempt. There, a single failure must bump the right counter, raise the timeout and clear the enable bit in the same edge, and it must not open a retry gap. The bench reaches it by programming small retry limits and answering each request with a chosen mix of outcome codes, so that the final failure lands on an exact, known attempt number. The gap cycle between attempts and the set-versus-clear race on the interrupt bits are also reached by timing the `att_done` pulse and the register write to the same edge.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef enum logic [1:0] {
    RES_ACK  = 2'd0,
    RES_NACK = 2'd1,
    RES_LOW  = 2'd2,
    RES_ARB  = 2'd3
  } txr_res_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GAP  = 2'd2
  } txr_state_e;

  localparam int unsigned TXR_CNT_W = 4;

  // Clamp a requested length to the buffer size.
  function automatic int unsigned clamp_len(int unsigned v, int unsigned mx);
    return (v > mx) ? mx : v;
  endfunction

  // True when the number of failures so far leaves no attempt to spare.
  function automatic logic tries_used_up(int unsigned fails, int unsigned lim);
    return fails > lim;
  endfunction

endpackage

// File: rtl/txr_regfile.sv
module txr_regfile #(
  parameter int unsigned FRAME_MAX = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LEN_W     = 5,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned LIM_W     = 3,
  parameter int unsigned LIM_LSB   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              wr_frame,
  input  logic              wr_len,
  input  logic              wr_retry,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [IDX_W-1:0]  eng_idx,
  output logic [DATA_W-1:0] sw_byte,
  output logic [DATA_W-1:0] eng_byte,
  output logic [LEN_W-1:0]  len_q,
  output logic [LIM_W-1:0]  lim_q,
  output logic              wr_blocked
);

  logic [DATA_W-1:0] mem [FRAME_MAX];
  logic wr_ok;

  assign wr_blocked = busy & (wr_frame | wr_len | wr_retry);
  assign wr_ok      = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(FRAME_MAX); i++) mem[i] <= '0;
      len_q <= '0;
      lim_q <= '0;
    end else if (wr_ok) begin
      if (wr_frame) mem[wr_idx] <= wr_data;
      if (wr_len)
        len_q <= LEN_W'(txr_pkg::clamp_len(int'(wr_data), FRAME_MAX));
      if (wr_retry) lim_q <= wr_data[LIM_LSB +: LIM_W];
    end
  end

  assign sw_byte  = mem[sw_idx];
  assign eng_byte = mem[eng_idx];

  AST_LOCKED_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_blocked && wr_len) |=> $stable(len_q)); // R9
  AST_LOCKED_LIM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_blocked && wr_retry) |=> $stable(lim_q)); // R9
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(len_q) <= int'(FRAME_MAX)); // R3

endmodule

// File: rtl/txr_seq.sv
module txr_seq #(
  parameter int unsigned LEN_W = 5,
  parameter int unsigned LIM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [LEN_W-1:0] len_q,
  input  logic [LIM_W-1:0] lim_q,
  input  logic             att_done,
  input  logic [1:0]       att_res,
  output logic             busy,
  output logic             att_req,
  output logic             ev_start,
  output logic             ev_ack,
  output logic             ev_arb,
  output logic             ev_nack,
  output logic             ev_low,
  output logic             ev_timeout
);
  import txr_pkg::*;

  localparam int unsigned FAIL_W = LIM_W + 1;

  txr_state_e        state_q;
  logic [FAIL_W-1:0] fails_q;
  logic [FAIL_W-1:0] fails_nx;
  logic              zero_start;
  logic              take;
  logic              ev_fail;
  logic              used_up;
  txr_res_e          res;

  assign res        = txr_res_e'(att_res);
  assign busy       = (state_q != ST_IDLE);
  assign att_req    = (state_q == ST_WAIT);
  assign ev_start   = start_req & ~busy;
  assign zero_start = ev_start & (len_q == '0);
  assign take       = att_req & att_done;
  assign ev_ack     = take & (res == RES_ACK);
  assign ev_arb     = take & (res == RES_ARB);
  assign ev_nack    = take & (res == RES_NACK);
  assign ev_low     = take & (res == RES_LOW);
  assign ev_fail    = ev_nack | ev_low;
  assign fails_nx   = fails_q + 1'b1;
  assign used_up    = tries_used_up(int'(fails_nx), int'(lim_q));
  assign ev_timeout = zero_start | (ev_fail & used_up);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fails_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ev_start && !zero_start) begin
            state_q <= ST_WAIT;
            fails_q <= '0;
          end
        end
        ST_WAIT: begin
          if (ev_ack || ev_arb) begin
            state_q <= ST_IDLE;
          end else if (ev_fail) begin
            fails_q <= fails_nx;
            state_q <= used_up ? ST_IDLE : ST_GAP;
          end
        end
        ST_GAP:  state_q <= ST_WAIT;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ack, ev_arb, ev_timeout})); // R11
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack || ev_arb || ev_timeout) |=> !busy && !att_req); // R4
  AST_FAILS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (fails_q <= FAIL_W'(lim_q))); // R7
  AST_RETRY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fail && !ev_timeout) |=> !att_req ##1 att_req); // R7
  AST_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> !att_req); // R8

endmodule

// File: rtl/txr_fail_cnt.sv
module txr_fail_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v);
    return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= sat_inc(cnt);
  end

  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R12
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt != {CNT_W{1'b1}}) |=> (cnt == $past(cnt) + 1'b1)); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt)); // R6

endmodule

// File: rtl/txr_irq.sv
module txr_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] irq_q
);

  logic [N-1:0] keep;

  assign keep = clr_wr ? ~clr_mask : {N{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= (irq_q & keep) | set;
  end

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((irq_q & $past(set)) == $past(set))); // R10
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && set == '0) |=> ((irq_q & $past(clr_mask)) == '0)); // R10

endmodule

// File: rtl/txr_frame_ctrl.sv
module txr_frame_ctrl #(
  parameter int unsigned FRAME_MAX = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = txr_pkg::TXR_CNT_W,
  parameter int unsigned LIM_W     = 3,
  parameter int unsigned LIM_LSB   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr_en,
  input  logic [$clog2(FRAME_MAX):0]    reg_addr,
  input  logic [DATA_W-1:0]             reg_wr_data,
  output logic [DATA_W-1:0]             reg_rd_data,
  output logic                          att_req,
  output logic [$clog2(FRAME_MAX+1)-1:0] att_len,
  input  logic [$clog2(FRAME_MAX)-1:0]  att_idx,
  output logic [DATA_W-1:0]             att_byte,
  input  logic                          att_done,
  input  logic [1:0]                    att_result,
  output logic                          irq_ready,
  output logic                          irq_arb_lost,
  output logic                          irq_retry_timeout
);

  localparam int unsigned IDX_W   = $clog2(FRAME_MAX);
  localparam int unsigned ADDR_W  = IDX_W + 1;
  localparam int unsigned LEN_W   = $clog2(FRAME_MAX + 1);
  localparam int unsigned N_IRQ   = 3;
  localparam int unsigned N_KIND  = 2;
  localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(FRAME_MAX);
  localparam logic [ADDR_W-1:0] A_RETRY = ADDR_W'(FRAME_MAX + 1);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(FRAME_MAX + 2);
  localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(FRAME_MAX + 3);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(FRAME_MAX + 4);

  logic               in_frame;
  logic               wr_frame, wr_len, wr_retry, wr_en_reg, wr_irq;
  logic               start_req;
  logic               busy;
  logic               wr_blocked;
  logic               ev_start, ev_ack, ev_arb, ev_nack, ev_low, ev_timeout;
  logic [DATA_W-1:0]  sw_byte;
  logic [LEN_W-1:0]   len_q;
  logic [LIM_W-1:0]   lim_q;
  logic [N_IRQ-1:0]   irq_q;
  logic [N_KIND-1:0]  kind_inc;
  logic [CNT_W-1:0]   cnts [N_KIND];

  assign in_frame  = (reg_addr < A_LEN);
  assign wr_frame  = reg_wr_en & in_frame;
  assign wr_len    = reg_wr_en & (reg_addr == A_LEN);
  assign wr_retry  = reg_wr_en & (reg_addr == A_RETRY);
  assign wr_en_reg = reg_wr_en & (reg_addr == A_EN);
  assign wr_irq    = reg_wr_en & (reg_addr == A_IRQ);
  assign start_req = wr_en_reg & reg_wr_data[0];

  txr_regfile #(
    .FRAME_MAX(FRAME_MAX), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .IDX_W(IDX_W), .LIM_W(LIM_W), .LIM_LSB(LIM_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .wr_frame(wr_frame), .wr_len(wr_len), .wr_retry(wr_retry),
    .wr_idx(reg_addr[IDX_W-1:0]), .wr_data(reg_wr_data),
    .sw_idx(reg_addr[IDX_W-1:0]), .eng_idx(att_idx),
    .sw_byte(sw_byte), .eng_byte(att_byte),
    .len_q(len_q), .lim_q(lim_q), .wr_blocked(wr_blocked)
  );

  txr_seq #(.LEN_W(LEN_W), .LIM_W(LIM_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .len_q(len_q), .lim_q(lim_q),
    .att_done(att_done), .att_res(att_result),
    .busy(busy), .att_req(att_req),
    .ev_start(ev_start), .ev_ack(ev_ack), .ev_arb(ev_arb),
    .ev_nack(ev_nack), .ev_low(ev_low), .ev_timeout(ev_timeout)
  );

  // Kind 0 counts not-acknowledged attempts, kind 1 counts low-drive attempts.
  assign kind_inc = {ev_low, ev_nack};

  for (genvar k = 0; k < int'(N_KIND); k++) begin : g_cnt
    txr_fail_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(ev_start),
      .inc(kind_inc[k]), .cnt(cnts[k])
    );
  end

  txr_irq #(.N(N_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set({ev_timeout, ev_arb, ev_ack}),
    .clr_wr(wr_irq), .clr_mask(reg_wr_data[N_IRQ-1:0]),
    .irq_q(irq_q)
  );

  assign irq_ready         = irq_q[0];
  assign irq_arb_lost      = irq_q[1];
  assign irq_retry_timeout = irq_q[2];
  assign att_len           = len_q;

  always_comb begin
    reg_rd_data = '0;
    if (in_frame)                 reg_rd_data = sw_byte;
    else if (reg_addr == A_LEN)   reg_rd_data = DATA_W'(len_q);
    else if (reg_addr == A_RETRY) reg_rd_data = DATA_W'({lim_q, {LIM_LSB{1'b0}}});
    else if (reg_addr == A_EN)    reg_rd_data = DATA_W'(busy);
    else if (reg_addr == A_IRQ)   reg_rd_data = DATA_W'(irq_q);
    else if (reg_addr == A_CNT)   reg_rd_data = DATA_W'({cnts[1], cnts[0]});
  end

  AST_ARB_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb |=> ($stable(cnts[0]) && $stable(cnts[1]))); // R5
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |-> !ev_start); // R9
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kind_inc)); // R6
  AST_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |-> busy); // R9

endmodule

// File: tb/sim_txr_frame_ctrl.sv
module sim_txr_frame_ctrl;

  localparam logic [4:0] A_LEN = 5'd16, A_RETRY = 5'd17, A_EN = 5'd18,
                         A_IRQ = 5'd19, A_CNT = 5'd20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic       att_req;
  logic [4:0] att_len;
  logic [3:0] att_idx = '0;
  logic [7:0] att_byte;
  logic       att_done = 1'b0;
  logic [1:0] att_result = '0;
  logic       irq_ready, irq_arb_lost, irq_retry_timeout;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  txr_frame_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .att_req(att_req), .att_len(att_len), .att_idx(att_idx),
    .att_byte(att_byte), .att_done(att_done), .att_result(att_result),
    .irq_ready(irq_ready), .irq_arb_lost(irq_arb_lost),
    .irq_retry_timeout(irq_retry_timeout)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rd_data;
  endtask

  // Answer the pending request with an outcome; returns just after the next negedge.
  task automatic attempt(logic [1:0] res);
    att_done = 1'b1; att_result = res;
    @(negedge clk);
    att_done = 1'b0;
  endtask

  function automatic logic [2:0] irqs();
    return {irq_retry_timeout, irq_arb_lost, irq_ready};
  endfunction

  task automatic prep(int len, int lim);
    wr(A_IRQ, 8'h07);
    wr(A_LEN, 8'(len));
    wr(A_RETRY, 8'(lim << 4));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_EN, d);  check("R1 enable", d, 0);
    rd(A_IRQ, d); check("R1 irq reg", d, 0);
    rd(A_CNT, d); check("R1 counters", d, 0);
    rd(A_LEN, d); check("R1 length", d, 0);
    rd(5'd3, d);  check("R1 frame byte", d, 0);
    check("R1 att_req", att_req, 0);
    check("R1 irq pins", irqs(), 0);
  endtask

  task automatic t_frame();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) wr(5'(i), 8'(8'hA0 + i * 3));
    rd(5'd5, d); check("R3 sw readback", d, 8'hAF);
    att_idx = 4'd7; #1;
    check("R3 att_byte", att_byte, 8'hB5);
    wr(A_LEN, 8'd40);
    check("R3 length clamp", att_len, 16);
    wr(A_LEN, 8'd4);
    check("R3 att_len", att_len, 4);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    prep(4, 3);
    wr(A_EN, 8'h01);
    rd(A_EN, d); check("R2 enable reads 1", d, 1);
    check("R2 att_req", att_req, 1);
    rd(A_CNT, d); check("R2 counters zero", d, 0);
    attempt(2'd0);
    check("R4 ready irq", irqs(), 3'b001);
    check("R4 att_req low", att_req, 0);
    rd(A_EN, d); check("R4 enable cleared", d, 0);
  endtask

  task automatic t_nack_then_ack();
    logic [7:0] d;
    prep(2, 1);
    wr(A_EN, 8'h01);
    attempt(2'd1);
    check("R7 gap cycle", att_req, 0);
    rd(A_CNT, d); check("R6 nack count", d, 8'h01);
    check("R6 no irq yet", irqs(), 0);
    @(negedge clk);
    check("R7 request again", att_req, 1);
    attempt(2'd0);
    check("R4 ready after retry", irqs(), 3'b001);
    rd(A_CNT, d); check("R6 counters kept", d, 8'h01);
  endtask

  task automatic t_timeout_mix();
    logic [7:0] d;
    prep(3, 2);
    wr(A_EN, 8'h01);
    attempt(2'd1); @(negedge clk);
    attempt(2'd2); @(negedge clk);
    check("R7 third attempt offered", att_req, 1);
    attempt(2'd1);
    check("R7 timeout irq", irqs(), 3'b100);
    check("R7 no gap after last", att_req, 0);
    rd(A_EN, d); check("R7 enable cleared", d, 0);
    rd(A_CNT, d); check("R6 packed counts", d, 8'h12);
  endtask

  task automatic t_limit_zero();
    logic [7:0] d;
    prep(1, 0);
    wr(A_EN, 8'h01);
    rd(A_CNT, d); check("R12 counters cleared on start", d, 0);
    attempt(2'd2);
    check("R7 single attempt", irqs(), 3'b100);
    rd(A_CNT, d); check("R6 low count", d, 8'h10);
  endtask

  task automatic t_arb();
    logic [7:0] d;
    prep(2, 3);
    wr(A_EN, 8'h01);
    attempt(2'd2); @(negedge clk);
    attempt(2'd3);
    check("R5 arb irq only", irqs(), 3'b010);
    check("R5 no retry", att_req, 0);
    @(negedge clk);
    check("R5 still no retry", att_req, 0);
    rd(A_CNT, d); check("R5 counters unchanged", d, 8'h10);
    rd(A_EN, d); check("R5 enable cleared", d, 0);
  endtask

  task automatic t_zero_len();
    logic [7:0] d;
    prep(0, 3);
    wr(A_EN, 8'h01);
    check("R8 no request", att_req, 0);
    check("R8 timeout irq", irqs(), 3'b100);
    rd(A_EN, d); check("R8 enable stays 0", d, 0);
    rd(A_CNT, d); check("R8 counters zero", d, 0);
  endtask

  task automatic t_busy_lock();
    logic [7:0] d;
    prep(3, 1);
    wr(5'd0, 8'h55);
    wr(A_EN, 8'h01);
    wr(A_LEN, 8'd9);
    wr(A_RETRY, 8'h70);
    wr(5'd0, 8'hEE);
    wr(A_EN, 8'h01);
    wr(A_EN, 8'h00);
    rd(A_LEN, d); check("R9 length locked", d, 3);
    rd(A_RETRY, d); check("R9 retry locked", d, 8'h10);
    rd(5'd0, d); check("R9 frame locked", d, 8'h55);
    rd(A_EN, d); check("R9 enable unaffected", d, 1);
    attempt(2'd1); @(negedge clk);
    attempt(2'd1);
    check("R9 old limit used", irqs(), 3'b100);
  endtask

  task automatic t_irq_clear();
    prep(2, 0);
    wr(A_EN, 8'h01);
    attempt(2'd0);
    wr(A_IRQ, 8'h00);
    check("R10 write 0 keeps", irqs(), 3'b001);
    wr(A_IRQ, 8'h01);
    check("R10 write 1 clears", irqs(), 3'b000);
    wr(A_EN, 8'h01);
    // clear and set land on the same edge
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = A_IRQ; reg_wr_data = 8'h01;
    att_done = 1'b1; att_result = 2'd0;
    @(negedge clk);
    reg_wr_en = 1'b0; att_done = 1'b0;
    check("R10 set wins over clear", irqs(), 3'b001);
    check("R11 single outcome", irqs(), 3'b001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame();
    t_ack();
    t_nack_then_ack();
    t_timeout_mix();
    t_limit_zero();
    t_arb();
    t_zero_len();
    t_busy_lock();
    t_irq_clear();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule